// File: doc/BRIEF.md
# Capability-Checked Tile Access Gate

The gate sits on the outbound path between one processing tile and the on-chip interconnect. Every memory-mapped operation the tile issues names a capability slot. The gate looks that slot up in a small local register file and checks three things: the slot is enabled, the address lies inside the slot's region, and the slot grants the right the operation needs. An operation that passes goes to the interconnect through a registered valid/ready stage. It carries the slot's replica label as an extra field. An operation that fails is accepted from the tile and then discarded without any response, so the tile never stalls on a refused access and learns nothing from the refusal.

The tile has no path into the register file. Slots change only through a separate configuration port, which is meant to be driven by the output of a consensus voter. A slot update applies to operations accepted in later cycles. An operation accepted in the same cycle as the update is still judged against the old contents. The number of slots must be a power of two.

Top module: `cap_gate`

## Requirements
- R1: After reset, `net_valid_o` is 0, `req_ready_o` is 1, and every slot is disabled, so any request is dropped until a slot is configured.
- R2: A request accepted (`req_valid_i` and `req_ready_o` high at a clock edge) that passes the check appears on the net side after that edge. The net side carries the same address, write data and write flag (1 = write, 0 = read) as the request, and `net_label_o` equals the label of the named slot.
- R3: The address check passes only when base <= addr and addr < base + size, with the sum taken one bit wider than the address so that it never wraps. An address outside the region is dropped.
- R4: A write needs the slot's write permission bit, and a read needs its read permission bit. A request that lacks the needed bit is dropped even when its address is in range.
- R5: A slot whose enable bit is 0 fails every request, whatever its base, size and permissions.
- R6: A dropped request is still accepted (`req_ready_o` high), and `net_valid_o` stays 0 in the following cycle.
- R7: The slots change only when `cfg_valid_i` is high at a clock edge. All fields of slot `cfg_idx_i` are then replaced. The new contents decide requests accepted from the next edge onward, and a request accepted at the same edge uses the old contents.
- R8: While `net_valid_o` is 1 and `net_ready_i` is 0, the net-side fields hold steady and `req_ready_o` is 0. When the net side accepts and no new request is taken, `net_valid_o` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Tile request valid |
| req_ready_o | output | 1 | Gate can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| req_cap_i | input | IW | Capability slot named by the request |
| net_valid_o | output | 1 | Forwarded operation valid |
| net_ready_i | input | 1 | Interconnect accepts the operation |
| net_write_o | output | 1 | Forwarded write flag |
| net_addr_o | output | AW | Forwarded address |
| net_wdata_o | output | DW | Forwarded write data |
| net_label_o | output | LW | Replica label from the slot |
| cfg_valid_i | input | 1 | Voted slot update strobe |
| cfg_idx_i | input | IW | Slot to update |
| cfg_en_i | input | 1 | New enable bit |
| cfg_base_i | input | AW | New region base |
| cfg_size_i | input | AW | New region size in bytes |
| cfg_rd_i | input | 1 | New read permission |
| cfg_wr_i | input | 1 | New write permission |
| cfg_label_i | input | LW | New replica label |

## Verification
The properties assume that the interconnect follows valid/ready rules and that a request's fields are steady during the cycle it is offered. They also assume that `cfg_idx_i` names an existing slot, which holds whenever the slot count is a power of two. The bench changes every input only on the falling clock edge. It raises `req_valid_i` for a single accepted cycle at a time, lowers `net_ready_i` only in the back-pressure case, and overlaps a configuration write with a request on purpose in exactly one directed case.

// File: rtl/cap_gate_pkg.sv
package cap_gate_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/cap_regfile.sv
module cap_regfile #(
  parameter int NCAP = 8,
  parameter int AW   = 32,
  parameter int LW   = 4,
  localparam int IW  = $clog2(NCAP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic          cfg_en_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_size_i,
  input  logic          cfg_rd_i,
  input  logic          cfg_wr_i,
  input  logic [LW-1:0] cfg_label_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_base_o,
  output logic [AW-1:0] rd_size_o,
  output logic          rd_r_o,
  output logic          rd_w_o,
  output logic [LW-1:0] rd_label_o
);
  logic          en_q    [NCAP];
  logic [AW-1:0] base_q  [NCAP];
  logic [AW-1:0] size_q  [NCAP];
  logic          r_q     [NCAP];
  logic          w_q     [NCAP];
  logic [LW-1:0] label_q [NCAP];

  for (genvar i = 0; i < NCAP; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]    <= 1'b0;
        base_q[i]  <= '0;
        size_q[i]  <= '0;
        r_q[i]     <= 1'b0;
        w_q[i]     <= 1'b0;
        label_q[i] <= '0;
      end else if (cfg_we_i && (cfg_idx_i == IW'(i))) begin
        en_q[i]    <= cfg_en_i;
        base_q[i]  <= cfg_base_i;
        size_q[i]  <= cfg_size_i;
        r_q[i]     <= cfg_rd_i;
        w_q[i]     <= cfg_wr_i;
        label_q[i] <= cfg_label_i;
      end
    end
  end

  assign rd_en_o    = en_q[rd_idx_i];
  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_size_o  = size_q[rd_idx_i];
  assign rd_r_o     = r_q[rd_idx_i];
  assign rd_w_o     = w_q[rd_idx_i];
  assign rd_label_o = label_q[rd_idx_i];
endmodule

// File: rtl/cap_check.sv
module cap_check
  import cap_gate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic          r_i,
  input  logic          w_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  output logic          ok_o
);
  logic [AW:0] addr_x, base_x, end_x;
  logic        in_range, perm;
  op_e         op;

  // one extra bit so base + size never wraps
  assign addr_x   = {1'b0, addr_i};
  assign base_x   = {1'b0, base_i};
  assign end_x    = base_x + {1'b0, size_i};
  assign in_range = (addr_x >= base_x) && (addr_x < end_x);
  assign op       = write_i ? OP_WRITE : OP_READ;

  always_comb begin
    unique case (op)
      OP_WRITE: perm = w_i;
      default:  perm = r_i;
    endcase
  end

  assign ok_o = en_i && in_range && perm;
endmodule

// File: rtl/cap_out_stage.sv
module cap_out_stage #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          pass_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [LW-1:0] label_i,
  output logic          ready_o,
  output logic          valid_o,
  input  logic          out_ready_i,
  output logic          write_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [LW-1:0] label_o
);
  logic valid_q;

  assign ready_o = !valid_q || out_ready_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (take_i) begin
      valid_q <= pass_i;  // a refused request leaves nothing behind
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      label_o <= '0;
    end else if (take_i && pass_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      label_o <= label_i;
    end
  end
endmodule

// File: rtl/cap_gate.sv
module cap_gate #(
  parameter int NCAP = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LW   = 4,
  localparam int IW  = $clog2(NCAP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [IW-1:0] req_cap_i,
  output logic          net_valid_o,
  input  logic          net_ready_i,
  output logic          net_write_o,
  output logic [AW-1:0] net_addr_o,
  output logic [DW-1:0] net_wdata_o,
  output logic [LW-1:0] net_label_o,
  input  logic          cfg_valid_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic          cfg_en_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_size_i,
  input  logic          cfg_rd_i,
  input  logic          cfg_wr_i,
  input  logic [LW-1:0] cfg_label_i
);
  logic          slot_en, slot_r, slot_w;
  logic [AW-1:0] slot_base, slot_size;
  logic [LW-1:0] slot_label;
  logic          pass, take;

  cap_regfile #(.NCAP(NCAP), .AW(AW), .LW(LW)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_valid_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_size_i  (cfg_size_i),
    .cfg_rd_i    (cfg_rd_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_label_i (cfg_label_i),
    .rd_idx_i    (req_cap_i),
    .rd_en_o     (slot_en),
    .rd_base_o   (slot_base),
    .rd_size_o   (slot_size),
    .rd_r_o      (slot_r),
    .rd_w_o      (slot_w),
    .rd_label_o  (slot_label)
  );

  cap_check #(.AW(AW)) u_check (
    .en_i    (slot_en),
    .base_i  (slot_base),
    .size_i  (slot_size),
    .r_i     (slot_r),
    .w_i     (slot_w),
    .addr_i  (req_addr_i),
    .write_i (req_write_i),
    .ok_o    (pass)
  );

  assign take = req_valid_i && req_ready_o;

  cap_out_stage #(.AW(AW), .DW(DW), .LW(LW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .pass_i      (pass),
    .write_i     (req_write_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .label_i     (slot_label),
    .ready_o     (req_ready_o),
    .valid_o     (net_valid_o),
    .out_ready_i (net_ready_i),
    .write_o     (net_write_o),
    .addr_o      (net_addr_o),
    .wdata_o     (net_wdata_o),
    .label_o     (net_label_o)
  );
endmodule

// File: rtl/cap_gate_sva.sv
module cap_gate_sva #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          net_valid_o,
  input logic          net_ready_i,
  input logic          net_write_o,
  input logic [AW-1:0] net_addr_o,
  input logic [DW-1:0] net_wdata_o,
  input logic [LW-1:0] net_label_o,
  input logic          pass
);
  assert_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && pass |=> net_valid_o);

  assert_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(net_valid_o) |-> $past(req_valid_i && req_ready_o));

  assert_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !pass |=> !net_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && !net_ready_i |=> net_valid_o && $stable(net_addr_o) &&
      $stable(net_wdata_o) && $stable(net_label_o) && $stable(net_write_o));

  assert_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && !net_ready_i |-> !req_ready_o);

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && net_ready_i && !(req_valid_i && req_ready_o) |=> !net_valid_o);
endmodule

bind cap_gate cap_gate_sva #(.AW(AW), .DW(DW), .LW(LW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .net_valid_o (net_valid_o),
  .net_ready_i (net_ready_i),
  .net_write_o (net_write_o),
  .net_addr_o  (net_addr_o),
  .net_wdata_o (net_wdata_o),
  .net_label_o (net_label_o),
  .pass        (pass)
);

// File: tb/cap_gate_tb.sv
module cap_gate_tb;
  localparam int NCAP = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int IW = $clog2(NCAP);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [IW-1:0] req_cap_i = '0;
  logic          net_valid_o, net_write_o;
  logic          net_ready_i = 1'b1;
  logic [AW-1:0] net_addr_o;
  logic [DW-1:0] net_wdata_o;
  logic [LW-1:0] net_label_o;
  logic          cfg_valid_i = 1'b0, cfg_en_i = 1'b0, cfg_rd_i = 1'b0, cfg_wr_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic [AW-1:0] cfg_base_i = '0, cfg_size_i = '0;
  logic [LW-1:0] cfg_label_i = '0;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  cap_gate #(.NCAP(NCAP), .AW(AW), .DW(DW), .LW(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_cap_i(req_cap_i),
    .net_valid_o(net_valid_o), .net_ready_i(net_ready_i), .net_write_o(net_write_o),
    .net_addr_o(net_addr_o), .net_wdata_o(net_wdata_o), .net_label_o(net_label_o),
    .cfg_valid_i(cfg_valid_i), .cfg_idx_i(cfg_idx_i), .cfg_en_i(cfg_en_i),
    .cfg_base_i(cfg_base_i), .cfg_size_i(cfg_size_i), .cfg_rd_i(cfg_rd_i),
    .cfg_wr_i(cfg_wr_i), .cfg_label_i(cfg_label_i)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [2:0]  cap;
    logic        fwd;
    logic [3:0]  lbl;
  } vec_t;

  // slots: 0 rw [1000,1100) L1; 1 ro [2000,2040) L2; 2 disabled rw [3000,3100) L3;
  // 3 rw [FFFFFF00, 2^32) L5; 4 rw base FFFFFFF0 size 100 L6; 5 wo [5000,5010) L7
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 3'd0, 1'b1, 4'd1},  // R2 R3 low edge
    '{1'b1, 32'h0000_10FF, 3'd0, 1'b1, 4'd1},  // R3 last byte
    '{1'b1, 32'h0000_1100, 3'd0, 1'b0, 4'd0},  // R3 one past end
    '{1'b1, 32'h0000_0FFF, 3'd0, 1'b0, 4'd0},  // R3 below base
    '{1'b0, 32'h0000_1080, 3'd0, 1'b1, 4'd1},  // R2 read
    '{1'b0, 32'h0000_2010, 3'd1, 1'b1, 4'd2},  // R4 read on read-only
    '{1'b1, 32'h0000_2010, 3'd1, 1'b0, 4'd0},  // R4 write on read-only
    '{1'b1, 32'h0000_3000, 3'd2, 1'b0, 4'd0},  // R5
    '{1'b0, 32'h0000_3000, 3'd2, 1'b0, 4'd0},  // R5
    '{1'b1, 32'hFFFF_FFFF, 3'd3, 1'b1, 4'd5},  // R3 top of space
    '{1'b1, 32'h0000_0010, 3'd4, 1'b0, 4'd0},  // R3 no wrap
    '{1'b1, 32'hFFFF_FFF8, 3'd4, 1'b1, 4'd6},  // R3
    '{1'b0, 32'h0000_5000, 3'd5, 1'b0, 4'd0},  // R4 read on write-only
    '{1'b1, 32'h0000_5004, 3'd5, 1'b1, 4'd7},  // R4 write on write-only
    '{1'b1, 32'h0000_1000, 3'd6, 1'b0, 4'd0}   // R1 never configured
  };

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic en, input logic [31:0] base,
                     input logic [31:0] size, input logic rd, input logic wr,
                     input logic [3:0] lbl);
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_idx_i = IW'(idx); cfg_en_i = en; cfg_base_i = base;
    cfg_size_i = size; cfg_rd_i = rd; cfg_wr_i = wr; cfg_label_i = lbl;
    @(posedge clk); #1;
    cfg_valid_i = 1'b0;
  endtask

  task automatic do_req(input logic wr, input logic [31:0] addr, input logic [2:0] cap,
                        input logic fwd, input logic [3:0] lbl, input string tag);
    logic [31:0] data;
    data = addr ^ 32'hA5A5_0000;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr;
    req_wdata_i = data; req_cap_i = cap;
    check(req_ready_o == 1'b1, {tag, " R6 ready"}, 64'(req_ready_o), 64'd1);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    check(net_valid_o == fwd, {tag, " valid"}, 64'(net_valid_o), 64'(fwd));
    if (fwd) begin
      check(net_addr_o == addr, {tag, " R2 addr"}, 64'(net_addr_o), 64'(addr));
      check(net_wdata_o == data, {tag, " R2 data"}, 64'(net_wdata_o), 64'(data));
      check(net_write_o == wr, {tag, " R2 write"}, 64'(net_write_o), 64'(wr));
      check(net_label_o == lbl, {tag, " R2 label"}, 64'(net_label_o), 64'(lbl));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #9;
    rst_ni = 1'b1;
    @(negedge clk);
    check(net_valid_o == 1'b0, "R1 reset valid", 64'(net_valid_o), 64'd0);
    check(req_ready_o == 1'b1, "R1 reset ready", 64'(req_ready_o), 64'd1);
    do_req(1'b1, 32'h0000_0000, 3'd0, 1'b0, 4'd0, "R1 empty slot");

    cfg(0, 1'b1, 32'h0000_1000, 32'h100, 1'b1, 1'b1, 4'd1);
    cfg(1, 1'b1, 32'h0000_2000, 32'h40,  1'b1, 1'b0, 4'd2);
    cfg(2, 1'b0, 32'h0000_3000, 32'h100, 1'b1, 1'b1, 4'd3);
    cfg(3, 1'b1, 32'hFFFF_FF00, 32'h100, 1'b1, 1'b1, 4'd5);
    cfg(4, 1'b1, 32'hFFFF_FFF0, 32'h100, 1'b1, 1'b1, 4'd6);
    cfg(5, 1'b1, 32'h0000_5000, 32'h10,  1'b0, 1'b1, 4'd7);

    for (int i = 0; i < NV; i++)
      do_req(VECS[i].wr, VECS[i].addr, VECS[i].cap, VECS[i].fwd, VECS[i].lbl,
             $sformatf("vec%0d", i));

    // R7: grant write on slot 1, then revoke slot 0
    cfg(1, 1'b1, 32'h0000_2000, 32'h40, 1'b1, 1'b1, 4'd9);
    do_req(1'b1, 32'h0000_2010, 3'd1, 1'b1, 4'd9, "R7 granted");
    cfg(0, 1'b0, 32'h0000_1000, 32'h100, 1'b1, 1'b1, 4'd1);
    do_req(1'b1, 32'h0000_1000, 3'd0, 1'b0, 4'd0, "R7 revoked");

    // R7: update to slot 3 in the same cycle as a request uses old contents
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_idx_i = 3'd3; cfg_en_i = 1'b0; cfg_base_i = '0;
    cfg_size_i = '0; cfg_rd_i = 1'b0; cfg_wr_i = 1'b0; cfg_label_i = '0;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 32'hFFFF_FF10;
    req_wdata_i = 32'h1234_5678; req_cap_i = 3'd3;
    @(posedge clk); #1;
    cfg_valid_i = 1'b0; req_valid_i = 1'b0;
    check(net_valid_o == 1'b1, "R7 same-cycle old slot", 64'(net_valid_o), 64'd1);
    check(net_label_o == 4'd5, "R7 same-cycle label", 64'(net_label_o), 64'd5);
    do_req(1'b1, 32'hFFFF_FF10, 3'd3, 1'b0, 4'd0, "R7 after update");

    // R8: back-pressure
    @(negedge clk);
    net_ready_i = 1'b0;
    do_req(1'b0, 32'h0000_2020, 3'd1, 1'b1, 4'd9, "R8 stall load");
    @(negedge clk);
    check(req_ready_o == 1'b0, "R8 ready low", 64'(req_ready_o), 64'd0);
    @(posedge clk); #1;
    check(net_valid_o == 1'b1, "R8 held valid", 64'(net_valid_o), 64'd1);
    check(net_addr_o == 32'h0000_2020, "R8 held addr", 64'(net_addr_o), 64'h2020);
    @(negedge clk);
    net_ready_i = 1'b1;
    @(posedge clk); #1;
    check(net_valid_o == 1'b0, "R8 released", 64'(net_valid_o), 64'd0);
    check(req_ready_o == 1'b1, "R8 ready again", 64'(req_ready_o), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule